// File: doc/BRIEF.md
# Canonical Signed-Digit Recoder

This block converts an unsigned binary constant into its canonical signed-digit form. Every digit of that form is -1, 0 or +1, and the form is the non-adjacent one: it has no two neighbouring nonzero digits. A constant-coefficient multiplier built from shifted adds and subtracts needs one adder per nonzero digit. The canonical form keeps that number of digits as small as it can be.

A word is presented on `bin_i` together with `valid_i`. One clock later the block shows the digit vector, the number of its nonzero digits and `valid_o`. The output carries one digit more than the input, so a run of ones that reaches the top bit can carry out. A single carry-ripple pass performs the whole recoding. There is no repeated run-replacement, and a run of ones merged by an earlier replacement is recoded in the same pass as the rest.

Top module: `csd_recoder`

## Requirements
- R1: Each digit i sits at `digits_o[2i+1:2i]` and is coded 2'b00 = 0, 2'b01 = +1, 2'b11 = -1. The code 2'b10 never appears.
- R2: The signed sum over all digits of digit_i * 2^i equals the input word that was captured.
- R3: No two adjacent digits are both nonzero.
- R4: The digit vector equals the unique non-adjacent form of the input, so no signed-digit form of that input has fewer nonzero digits. For example, 0x1EF recodes to +1 at digit 9, -1 at digits 4 and 0, and 0 elsewhere, which is 3 nonzero digits.
- R5: `nz_cnt_o` equals the number of nonzero digits in `digits_o` and never exceeds (N+2)/2.
- R6: `valid_o` is `valid_i` delayed by exactly one clock.
- R7: While `valid_i` is low, `digits_o` and `nz_cnt_o` keep their previous values.
- R8: While `rst_ni` is low, `valid_o`, `digits_o` and `nz_cnt_o` are all zero.
- R9: A run of ones that includes input bit N-1 carries into digit N. An all-ones input gives +1 at digit N, -1 at digit 0 and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word strobe |
| bin_i | input | N | Unsigned constant to recode |
| valid_o | output | 1 | Result strobe, one clock after valid_i |
| digits_o | output | 2*(N+1) | Signed digit vector, 2 bits per digit |
| nz_cnt_o | output | $clog2(N+2) | Count of nonzero digits |

## Verification
The directed words cover the cases that separate the canonical form from weaker recodings:
- A short run of ones, which needs only one replacement.
- The 0x1EF pattern, which a single replacement pass leaves with adjacent nonzero digits.
- Alternating patterns, which are already canonical and must come out unchanged.
- All ones and a lone top bit, which exercise the carry into the extra digit.
- Zero.

Random words are compared digit by digit against a non-adjacent form that the bench computes arithmetically. This comparison catches a wrong sign, a dropped carry and a non-minimal weight. Gaps with the strobe low show whether the outputs hold their values.

// File: rtl/csd_pkg.sv
package csd_pkg;
  typedef enum logic [1:0] {
    DIG_ZERO = 2'b00,
    DIG_POS  = 2'b01,
    DIG_NEG  = 2'b11
  } csd_digit_e;
endpackage

// File: rtl/csd_carry_chain.sv
module csd_carry_chain #(
  parameter int N  = 16,
  localparam int DW = N + 1
) (
  input  logic [N-1:0]    bin_i,
  output logic [2*DW-1:0] digits_o
);
  logic [N+1:0] xe;
  logic [DW:0]  c;

  assign xe   = {2'b00, bin_i};
  assign c[0] = 1'b0;

  for (genvar i = 0; i < DW; i++) begin : g_dig
    logic nz;
    // carry is the majority of this bit, the next bit and the incoming carry
    assign c[i+1] = (xe[i] & xe[i+1]) | (xe[i] & c[i]) | (xe[i+1] & c[i]);
    assign nz     = xe[i] ^ c[i];
    assign digits_o[2*i+1:2*i] = nz ? (c[i+1] ? csd_pkg::DIG_NEG : csd_pkg::DIG_POS)
                                    : csd_pkg::DIG_ZERO;
  end
endmodule

// File: rtl/csd_popcount.sv
module csd_popcount #(
  parameter int DW = 17,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic [2*DW-1:0] digits_i,
  output logic [CW-1:0]   cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < DW; i++) cnt_o = cnt_o + CW'(digits_i[2*i]);
  end
endmodule

// File: rtl/csd_recoder.sv
module csd_recoder #(
  parameter int N  = 16,
  localparam int DW = N + 1,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [N-1:0]    bin_i,
  output logic            valid_o,
  output logic [2*DW-1:0] digits_o,
  output logic [CW-1:0]   nz_cnt_o
);
  logic [2*DW-1:0] dig_d;
  logic [CW-1:0]   cnt_d;

  csd_carry_chain #(.N(N)) u_chain (
    .bin_i    (bin_i),
    .digits_o (dig_d)
  );

  csd_popcount #(.DW(DW)) u_pop (
    .digits_i (dig_d),
    .cnt_o    (cnt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      digits_o <= '0;
      nz_cnt_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        digits_o <= dig_d;
        nz_cnt_o <= cnt_d;
      end
    end
  end

  function automatic longint digit_sum(input logic [2*DW-1:0] d);
    longint acc = 0;
    for (int i = 0; i < DW; i++)
      if (d[2*i]) acc = d[2*i+1] ? acc - (longint'(1) << i) : acc + (longint'(1) << i);
    return acc;
  endfunction

  function automatic logic adj_nz(input logic [2*DW-1:0] d);
    logic r = 1'b0;
    for (int i = 0; i < DW - 1; i++) r = r | (d[2*i] & d[2*i+2]);
    return r;
  endfunction

  function automatic logic bad_code(input logic [2*DW-1:0] d);
    logic r = 1'b0;
    for (int i = 0; i < DW; i++) r = r | (d[2*i+1] & ~d[2*i]);
    return r;
  endfunction

  AST_LEGAL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_code(digits_o)); // R1
  AST_VALUE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> digit_sum(digits_o) == longint'($past(bin_i))); // R2
  AST_NON_ADJACENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adj_nz(digits_o)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(nz_cnt_o) <= (N + 2) / 2); // R5
  AST_VALID_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R6
  AST_VALID_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R6
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(digits_o) && $stable(nz_cnt_o)); // R7
endmodule

// File: tb/csd_recoder_tb.sv
module csd_recoder_tb;
  localparam int N  = 16;
  localparam int DW = N + 1;
  localparam int CW = $clog2(DW + 1);

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [N-1:0]    bin_i = '0;
  logic            valid_o;
  logic [2*DW-1:0] digits_o;
  logic [CW-1:0]   nz_cnt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  csd_recoder #(.N(N)) u_dut (
    .clk_i, .rst_ni, .valid_i, .bin_i, .valid_o, .digits_o, .nz_cnt_o
  );

  // Arithmetic NAF: pick +1/-1 from value mod 4 when odd
  function automatic logic [2*DW-1:0] ref_naf(input logic [N-1:0] x);
    logic [2*DW-1:0] r = '0;
    longint v = longint'(x);
    for (int i = 0; i < DW; i++) begin
      if (v % 2 == 1) begin
        if (v % 4 == 1) begin r[2*i +: 2] = 2'b01; v = v - 1; end
        else            begin r[2*i +: 2] = 2'b11; v = v + 1; end
      end
      v = v / 2;
    end
    return r;
  endfunction

  function automatic int ref_cnt(input logic [2*DW-1:0] d);
    int c = 0;
    for (int i = 0; i < DW; i++) if (d[2*i +: 2] != 2'b00) c++;
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] x, input string req);
    logic [2*DW-1:0] e;
    logic [2*DW-1:0] held;
    e = ref_naf(x);
    @(negedge clk_i);
    valid_i = 1'b1;
    bin_i   = x;
    @(negedge clk_i);
    valid_i = 1'b0;
    bin_i   = ~x;
    check(valid_o == 1'b1, "R6", $sformatf("%b", valid_o), "1");
    check(digits_o == e, req, $sformatf("%h", digits_o), $sformatf("%h", e));
    check(int'(nz_cnt_o) == ref_cnt(e), "R5", $sformatf("%0d", nz_cnt_o),
          $sformatf("%0d", ref_cnt(e)));
    held = digits_o;
    @(negedge clk_i);
    check(valid_o == 1'b0, "R6", $sformatf("%b", valid_o), "0");
    check(digits_o == held, "R7", $sformatf("%h", digits_o), $sformatf("%h", held));
  endtask

  initial begin
    #40000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    repeat (3) @(negedge clk_i);
    check(valid_o == 0 && digits_o == '0 && nz_cnt_o == '0, "R8",
          $sformatf("%b/%h/%0d", valid_o, digits_o, nz_cnt_o), "0/0/0");
    rst_ni = 1'b1;
    apply(16'h0000, "R4");
    apply(16'h0007, "R4");
    apply(16'h01EF, "R4");
    check(nz_cnt_o == 3, "R4", $sformatf("%0d", nz_cnt_o), "3");
    apply(16'h00ED, "R2");
    apply(16'hAAAA, "R3");
    apply(16'h5555, "R3");
    apply(16'h8000, "R9");
    apply(16'hFFFF, "R9");
    check(digits_o == {2'b01, {(2*DW-4){1'b0}}, 2'b11}, "R9",
          $sformatf("%h", digits_o), "top +1 bottom -1");
    apply(16'hC000, "R9");
    for (int k = 0; k < 300; k++) begin
      logic [N-1:0] x;
      x = N'($urandom);
      apply(x, "R1 R2 R3 R4");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule